// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block holds the coherence state of one line in a private cache attached to a snooping bus. It supports five states: Invalid, Shared, Exclusive, Owned and Modified. Each cycle it accepts at most one event. An event is either a local access (read, write or eviction) or a snooped transaction seen on the bus (bus read, bus write or bus upgrade). In response it drives bus requests, snoop responses, a supply-data strobe and a write-back strobe, and it loads the next state on the following clock edge. The Owned state marks a line that is dirty and also shared. The owner serves other caches directly and is the only cache that writes the line back. Any other copies exist only in Shared.

All action outputs are combinational from the current state and the event in the same cycle. The state register updates on the next rising edge. The shared-line input is only used while the controller issues its own bus read from Invalid. A forbidden event/state pair, or more than one event in a cycle, raises the error flag. In that case the controller suppresses every action and holds the state.

Named transitions:
- I→E: read fill with no sharers.
- I→S: read fill with sharers.
- I→M: write fill.
- S→M and O→M: upgrade.
- E→M: silent upgrade.
- E→S: snoop read in E.
- M→O: snoop read in M.
- S/E/O/M→I: eviction or snoop invalidation.

Top module: `moesi_line_ctrl`

## Requirements
- R1: When `rst_n` is low, the state goes to Invalid and all action outputs are 0. The state encoding is I=0, S=1, E=2, O=3, M=4.
- R2: In I, a local read raises `bus_rd_req`. The next state is E when `shared_in`=0 and S when `shared_in`=1. A local write raises `bus_wr_req` and the next state is M.
- R3: In I, an eviction is an error. Snooped bus read, bus write and bus upgrade produce no action and leave the state in I.
- R4: In S, a local read does nothing. A local write raises `bus_upg_req` and goes to M. An eviction goes to I. A snooped read raises `resp_shared` only. A snooped write or upgrade goes to I.
- R5: In E, a local write goes to M with no bus request. An eviction goes to I with no write-back. A snooped read raises `resp_shared` and `supply_data` and goes to S. A snooped write goes to I. A snooped upgrade is an error.
- R6: In O, a local write raises `bus_upg_req` and goes to M. An eviction raises `write_back` and goes to I. A snooped read raises `resp_shared`, `resp_dirty` and `supply_data` and stays in O. A snooped write raises `resp_dirty` and `supply_data` and goes to I. A snooped upgrade goes to I.
- R7: In M, a local read or write does nothing. An eviction raises `write_back` and goes to I. A snooped read raises `resp_shared`, `resp_dirty` and `supply_data` and goes to O. A snooped write raises `resp_dirty` and `supply_data` and goes to I. A snooped upgrade is an error.
- R8: If more than one event input is high in a cycle, `err_flag` is raised, every other action output is 0, and the state is held.
- R9: Whenever `err_flag` is raised, all other actions are 0 and the state is unchanged on the next edge.
- R10: With no event input high, all outputs are 0 and the state is held. A local read in S, E or O also does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_rd | input | 1 | Local read event |
| loc_wr | input | 1 | Local write event |
| loc_evict | input | 1 | Local eviction event |
| snp_rd | input | 1 | Snooped bus read |
| snp_wr | input | 1 | Snooped bus write |
| snp_upg | input | 1 | Snooped bus upgrade |
| shared_in | input | 1 | Shared-line level sampled during own bus read |
| state_q | output | 3 | Current line state |
| bus_rd_req | output | 1 | Issue bus read |
| bus_wr_req | output | 1 | Issue bus write |
| bus_upg_req | output | 1 | Issue bus upgrade |
| resp_shared | output | 1 | Snoop response: copy held |
| resp_dirty | output | 1 | Snoop response: copy dirty |
| supply_data | output | 1 | Supply line to requester |
| write_back | output | 1 | Write line back to memory |
| err_flag | output | 1 | Illegal event/state or multiple events |

## Verification
A local request and a snooped transaction can arrive in the same cycle. The controller must not act on either of them. The bench drives every pair of event inputs from every one of the five states. For each pair it checks that only `err_flag` is high in that cycle and that the state read after the edge equals the state before it. Every single event is also swept against every state and both `shared_in` levels, and the outputs are compared with expected values derived from the requirement table.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    localparam int NUM_EVT = 6;
    localparam int ST_W    = 3;

    typedef enum logic [ST_W-1:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_t;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_LRD  = 3'd1,
        EV_LWR  = 3'd2,
        EV_LEV  = 3'd3,
        EV_BRD  = 3'd4,
        EV_BWR  = 3'd5,
        EV_BUPG = 3'd6
    } evt_t;

    typedef struct packed {
        logic req_rd;
        logic req_wr;
        logic req_upg;
        logic rsp_sh;
        logic rsp_dty;
        logic supply;
        logic wback;
        logic err;
    } act_t;

endpackage

// File: rtl/moesi_evt_decode.sv
module moesi_evt_decode
    import moesi_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic [N-1:0] evt_vec,
    output evt_t         code,
    output logic         multi
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt  = '0;
        code = EV_NONE;
        for (int i = 0; i < N; i++) begin
            if (evt_vec[i]) begin
                cnt  = cnt + CW'(1);
                code = evt_t'(i + 1);
            end
        end
        multi = (cnt > CW'(1));
        if (multi) code = EV_NONE;
    end

endmodule

// File: rtl/moesi_next_logic.sv
module moesi_next_logic
    import moesi_pkg::*;
(
    input  line_state_t cur,
    input  evt_t        code,
    input  logic        multi,
    input  logic        shared_in,
    output line_state_t nxt,
    output act_t        act
);
    always_comb begin
        nxt = cur;
        act = '0;
        if (multi) begin
            act.err = 1'b1;
        end else begin
            unique case (cur)
                ST_I: begin
                    case (code)
                        EV_LRD: begin
                            act.req_rd = 1'b1;
                            nxt = shared_in ? ST_S : ST_E;
                        end
                        EV_LWR: begin
                            act.req_wr = 1'b1;
                            nxt = ST_M;
                        end
                        EV_LEV:  act.err = 1'b1;
                        default: ;
                    endcase
                end
                ST_S: begin
                    case (code)
                        EV_LWR: begin
                            act.req_upg = 1'b1;
                            nxt = ST_M;
                        end
                        EV_LEV:  nxt = ST_I;
                        EV_BRD:  act.rsp_sh = 1'b1;
                        EV_BWR,
                        EV_BUPG: nxt = ST_I;
                        default: ;
                    endcase
                end
                ST_E: begin
                    case (code)
                        EV_LWR: nxt = ST_M;
                        EV_LEV: nxt = ST_I;
                        EV_BRD: begin
                            act.rsp_sh = 1'b1;
                            act.supply = 1'b1;
                            nxt = ST_S;
                        end
                        EV_BWR:  nxt = ST_I;
                        EV_BUPG: act.err = 1'b1;
                        default: ;
                    endcase
                end
                ST_O: begin
                    case (code)
                        EV_LWR: begin
                            act.req_upg = 1'b1;
                            nxt = ST_M;
                        end
                        EV_LEV: begin
                            act.wback = 1'b1;
                            nxt = ST_I;
                        end
                        EV_BRD: begin
                            act.rsp_sh  = 1'b1;
                            act.rsp_dty = 1'b1;
                            act.supply  = 1'b1;
                        end
                        EV_BWR: begin
                            act.rsp_dty = 1'b1;
                            act.supply  = 1'b1;
                            nxt = ST_I;
                        end
                        EV_BUPG: nxt = ST_I;
                        default: ;
                    endcase
                end
                ST_M: begin
                    case (code)
                        EV_LEV: begin
                            act.wback = 1'b1;
                            nxt = ST_I;
                        end
                        EV_BRD: begin
                            act.rsp_sh  = 1'b1;
                            act.rsp_dty = 1'b1;
                            act.supply  = 1'b1;
                            nxt = ST_O;
                        end
                        EV_BWR: begin
                            act.rsp_dty = 1'b1;
                            act.supply  = 1'b1;
                            nxt = ST_I;
                        end
                        EV_BUPG: act.err = 1'b1;
                        default: ;
                    endcase
                end
                default: begin
                    act.err = 1'b1;
                    nxt = ST_I;
                end
            endcase
        end
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loc_rd,
    input  logic       loc_wr,
    input  logic       loc_evict,
    input  logic       snp_rd,
    input  logic       snp_wr,
    input  logic       snp_upg,
    input  logic       shared_in,
    output logic [2:0] state_q,
    output logic       bus_rd_req,
    output logic       bus_wr_req,
    output logic       bus_upg_req,
    output logic       resp_shared,
    output logic       resp_dirty,
    output logic       supply_data,
    output logic       write_back,
    output logic       err_flag
);
    line_state_t cur_q, nxt;
    evt_t        code;
    logic        multi;
    act_t        act;

    moesi_evt_decode #(.N(NUM_EVT)) u_dec (
        .evt_vec ({snp_upg, snp_wr, snp_rd, loc_evict, loc_wr, loc_rd}),
        .code    (code),
        .multi   (multi)
    );

    moesi_next_logic u_nxt (
        .cur       (cur_q),
        .code      (code),
        .multi     (multi),
        .shared_in (shared_in),
        .nxt       (nxt),
        .act       (act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_I;
        else        cur_q <= nxt;
    end

    always_comb begin
        state_q     = cur_q;
        bus_rd_req  = act.req_rd;
        bus_wr_req  = act.req_wr;
        bus_upg_req = act.req_upg;
        resp_shared = act.rsp_sh;
        resp_dirty  = act.rsp_dty;
        supply_data = act.supply;
        write_back  = act.wback;
        err_flag    = act.err;
    end

    // R9
    err_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> $stable(state_q));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !(bus_rd_req || bus_wr_req || bus_upg_req || supply_data || write_back));

    // R6
    wb_to_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_back |=> state_q == 3'd0);

    // R4
    upg_to_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upg_req |=> state_q == 3'd4);

    // R7
    supply_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |-> (state_q == 3'd2 || state_q == 3'd3 || state_q == 3'd4));

    // R2
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd_req, bus_wr_req, bus_upg_req}));

    // R5
    e_silent_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 3'd2 && loc_wr && !err_flag) |-> !bus_upg_req);

endmodule

// File: tb/sim_moesi_line_ctrl.sv
module sim_moesi_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic       sh = 1'b0;
    logic [2:0] st;
    logic       rd, wr, upg, rs, rdty, sup, wb, er;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    moesi_line_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .loc_rd(ev[0]), .loc_wr(ev[1]), .loc_evict(ev[2]),
        .snp_rd(ev[3]), .snp_wr(ev[4]), .snp_upg(ev[5]),
        .shared_in(sh), .state_q(st),
        .bus_rd_req(rd), .bus_wr_req(wr), .bus_upg_req(upg),
        .resp_shared(rs), .resp_dirty(rdty), .supply_data(sup),
        .write_back(wb), .err_flag(er)
    );

    // expected {next[2:0], rd, wr, upg, sh, dirty, supply, wb, err}
    function automatic logic [10:0] model(input logic [2:0] s, input int e, input logic shd);
        logic [2:0] n;
        logic [7:0] a;
        n = s;
        a = '0;
        case (s)
            3'd0: case (e)
                0: begin a = 8'b1000_0000; n = shd ? 3'd1 : 3'd2; end
                1: begin a = 8'b0100_0000; n = 3'd4; end
                2: a = 8'b0000_0001;
                default: ;
            endcase
            3'd1: case (e)
                1: begin a = 8'b0010_0000; n = 3'd4; end
                2: n = 3'd0;
                3: a = 8'b0001_0000;
                4, 5: n = 3'd0;
                default: ;
            endcase
            3'd2: case (e)
                1: n = 3'd4;
                2: n = 3'd0;
                3: begin a = 8'b0001_0100; n = 3'd1; end
                4: n = 3'd0;
                5: a = 8'b0000_0001;
                default: ;
            endcase
            3'd3: case (e)
                1: begin a = 8'b0010_0000; n = 3'd4; end
                2: begin a = 8'b0000_0010; n = 3'd0; end
                3: a = 8'b0001_1100;
                4: begin a = 8'b0000_1100; n = 3'd0; end
                5: n = 3'd0;
                default: ;
            endcase
            default: case (e)
                2: begin a = 8'b0000_0010; n = 3'd0; end
                3: begin a = 8'b0001_1100; n = 3'd3; end
                4: begin a = 8'b0000_1100; n = 3'd0; end
                5: a = 8'b0000_0001;
                default: ;
            endcase
        endcase
        return {n, a};
    endfunction

    function automatic string rtag(input logic [2:0] s, input int e);
        if (e < 0) return "R10";
        if (s == 3'd0) return (e <= 1) ? "R2" : "R3";
        if (s == 3'd1) return (e == 0) ? "R10" : "R4";
        if (s == 3'd2) return (e == 0) ? "R10" : "R5";
        if (s == 3'd3) return (e == 0) ? "R10" : "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic goto(input logic [2:0] s);
        @(negedge clk);
        ev = '0; sh = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        case (s)
            3'd1: begin ev = 6'b000001; sh = 1'b1; end
            3'd2: ev = 6'b000001;
            3'd3, 3'd4: ev = 6'b000010;
            default: ;
        endcase
        if (s != 3'd0) @(negedge clk);
        if (s == 3'd3) begin ev = 6'b001000; @(negedge clk); end
        ev = '0; sh = 1'b0;
        #1;
    endtask

    initial begin
        logic [10:0] x;
        // R1 reset state
        rst_n = 1'b0;
        #3;
        check("R1", "reset state", {29'd0, st}, 32'd0);
        check("R1", "reset actions", {24'd0, rd, wr, upg, rs, rdty, sup, wb, er}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // single-event sweep
        for (int s = 0; s < 5; s++) begin
            for (int e = -1; e < 6; e++) begin
                for (int h = 0; h < 2; h++) begin
                    goto(3'(s));
                    check("R1", "reach state", {29'd0, st}, 32'(s));
                    x = model(3'(s), e, h[0]);
                    ev = (e < 0) ? 6'b0 : 6'(1 << e);
                    sh = h[0];
                    #1;
                    check(rtag(3'(s), e), "actions",
                          {24'd0, rd, wr, upg, rs, rdty, sup, wb, er}, {24'd0, x[7:0]});
                    if (x[0]) check("R9", "err quiet", {31'd0, rd | wr | upg | sup | wb}, 32'd0);
                    @(negedge clk);
                    ev = '0; sh = 1'b0;
                    #1;
                    check(rtag(3'(s), e), "next state", {29'd0, st}, {29'd0, x[10:8]});
                end
            end
        end

        // R8 simultaneous events
        for (int s = 0; s < 5; s++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = a + 1; b < 6; b++) begin
                    goto(3'(s));
                    ev = 6'((1 << a) | (1 << b));
                    sh = 1'b1;
                    #1;
                    check("R8", "pair actions",
                          {24'd0, rd, wr, upg, rs, rdty, sup, wb, er}, 32'd1);
                    @(negedge clk);
                    ev = '0; sh = 1'b0;
                    #1;
                    check("R8", "pair state held", {29'd0, st}, 32'(s));
                end
            end
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule